// File: doc/BRIEF.md
# Byte-Wide EPROM Behavioral Model

A synthesizable stand-in for a small ultraviolet-erasable read-only memory, one byte wide and parameterized in depth. It is meant to sit in a self-checking bench as the device that a programmer or a processor model reads and writes. Control inputs are active low: a chip select, an output enable and a program strobe. Three flags stand in for analog levels: programming voltage present, core supply raised to its programming level, and the identification voltage on the address line. An erase input returns the whole array to the blank state.

On every clock the model turns the current controls into one operating mode. It drives stored bytes, identification bytes or nothing. It holds the data not-valid for a set number of cycles after an address or select change, and a shorter number after the output enable falls. When the outputs are switched off, it keeps driving them for a float window. A byte can be programmed only by a falling edge of the program strobe, and that write can only clear bits.

Top module: `byte_eprom_model`

## Requirements
- R1: During and after reset `rdata_drive`, `rdata_valid` and `access_err` are 0, `rdata` shows the filler byte `GAP_BYTE`, and every stored byte is 0xFF.
- R2: With select low, output enable low and `hv_supply` low, the outputs are driven, and once the delays have run out `rdata_valid` is 1 and `rdata` is the byte stored at the address. The program strobe plays no part in this.
- R3: With select high the outputs go undriven after the float window, whatever the output enable and program strobe do.
- R4: A new address, a change of `id_hv`, a falling select, a write or an erase each restart an access count. Data is valid only `ACC_CYC` edges after the edge that sampled the change. Until then `rdata` carries `GAP_BYTE` with `rdata_valid` 0 while the outputs are driven.
- R5: Once address and select have settled, a falling output enable gives valid data `OE_CYC` edges after the edge that sampled it.
- R6: After the edge that samples select or output enable rising, the outputs stay driven for `FLT_CYC` cycles with `rdata_valid` 0, and are then released.
- R7: With select low, output enable high, `hv_supply` and `vcc_boost` high, a falling edge of `prog_n` stores old byte AND `wdata`. With the output enable low and the strobe high under the same supplies (verify), the stored byte is read.
- R8: A strobe held low writes once. Changes of `wdata` while it stays low do not alter the byte.
- R9: With select high and `hv_supply` high (inhibit), a strobe pulse changes nothing and raises no error.
- R10: A falling strobe while select is low and `hv_supply` is low pulses `access_err` for one cycle and leaves the array unchanged.
- R11: With `hv_supply` high and `vcc_boost` low, or with both output enable and strobe low under the high supplies, the outputs are not valid. A falling strobe there pulses `access_err` and writes nothing.
- R12: With `id_hv` set, address bit 0 low reads `MFR_ID` (0x8F) and bit 0 high reads `DEV_ID` (0x83).
- R13: `erase_all` sets every byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also blanks the array |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Byte presented for programming |
| chip_sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output enable |
| prog_n | input | 1 | Active-low program strobe |
| hv_supply | input | 1 | Programming voltage present |
| vcc_boost | input | 1 | Core supply raised to programming level |
| id_hv | input | 1 | Identification voltage on the address line |
| erase_all | input | 1 | Set every bit to 1 |
| rdata | output | 8 | Read data, or GAP_BYTE while not valid |
| rdata_drive | output | 1 | Outputs driven (low means high impedance) |
| rdata_valid | output | 1 | rdata holds settled data |
| access_err | output | 1 | One-cycle pulse for a rejected program strobe |

## Verification
The bench reads blank bytes, then programs a byte twice with overlapping patterns (0xA7, then 0x5F), so only a true AND gives 0x07. Overwrite or OR behaviour would give 0x5F or 0xFF. A strobe is held low while the presented byte changes, which separates edge-triggered writes from level-triggered ones. Pulses are sent under inhibit, without programming voltage and with a supply fault. Among these, only the missing-voltage and fault cases may raise the error, and none may touch the array. Select, output-enable and address changes are timed separately, so that the long access count, the short enable count and the float window each show up on their own edge.

// File: rtl/eprom_pkg.sv
// Shared types for the byte-wide EPROM model.
// Assumes: one mode is decoded per clock from the sampled control levels.
package eprom_pkg;

    typedef enum logic [2:0] {
        EM_STANDBY = 3'd0,
        EM_INHIBIT = 3'd1,
        EM_OUT_OFF = 3'd2,
        EM_READ    = 3'd3,
        EM_VERIFY  = 3'd4,
        EM_PROGRAM = 3'd5,
        EM_FAULT   = 3'd6
    } eprom_mode_e;

    // True for the modes that put data on the outputs.
    function automatic logic mode_drives(eprom_mode_e m);
        return (m == EM_READ) || (m == EM_VERIFY);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
// Mode decoder: maps select, output enable, strobe and the two supply
// flags onto one operating mode.
// Assumes: purely combinational; the caller registers whatever it needs.
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic        chip_sel_n,
    input  logic        out_en_n,
    input  logic        prog_n,
    input  logic        hv_supply,
    input  logic        vcc_boost,
    output eprom_mode_e mode
);

    // Decode the operating mode from the present control levels.
    always_comb begin
        if (chip_sel_n) begin
            mode = hv_supply ? EM_INHIBIT : EM_STANDBY;
        end else if (!hv_supply) begin
            mode = out_en_n ? EM_OUT_OFF : EM_READ;
        end else if (!vcc_boost) begin
            mode = EM_FAULT;
        end else begin
            case ({out_en_n, prog_n})
                2'b10:   mode = EM_PROGRAM;
                2'b01:   mode = EM_VERIFY;
                2'b11:   mode = EM_OUT_OFF;
                default: mode = EM_FAULT;
            endcase
        end
    end

endmodule

// File: rtl/eprom_cell_array.sv
// Storage array: bytes that reset or erase to all ones and can only lose
// ones through a write (stored AND written).
// Assumes: at most one write per clock; erase wins over a write.
module eprom_cell_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_all,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Blank on reset or erase, otherwise clear bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_all) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    // Asynchronous read of the addressed byte.
    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eprom_out_timer.sv
// Output timing: counts the access, output-enable and float delays in
// clock cycles and decides when the outputs are driven and valid.
// Assumes: every delay parameter is at least 1.
module eprom_out_timer #(
    parameter int           DATA_W   = 8,
    parameter int           ACC_CYC  = 4,
    parameter int           OE_CYC   = 2,
    parameter int           FLT_CYC  = 2,
    parameter logic [7:0]   GAP_BYTE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_restart,
    input  logic              oe_restart,
    input  logic              drive_mode,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive,
    output logic              dout_valid
);

    localparam int MAX_AO  = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
    localparam int MAX_D   = (MAX_AO > FLT_CYC) ? MAX_AO : FLT_CYC;
    localparam int CNT_W   = $clog2(MAX_D + 1);
    localparam logic [CNT_W-1:0] ACC_LOAD = CNT_W'(ACC_CYC);
    localparam logic [CNT_W-1:0] OE_LOAD  = CNT_W'(OE_CYC);
    localparam logic [CNT_W-1:0] FLT_LOAD = CNT_W'(FLT_CYC);

    logic [CNT_W-1:0] acc_cnt;
    logic [CNT_W-1:0] oe_cnt;
    logic [CNT_W-1:0] flt_cnt;
    logic             drv_q;

    // Access countdown since the last address, select or content change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt <= '0;
        end else if (acc_restart) begin
            acc_cnt <= ACC_LOAD;
        end else if (acc_cnt != '0) begin
            acc_cnt <= acc_cnt - 1'b1;
        end
    end

    // Output-enable countdown since the enable last fell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_cnt <= '0;
        end else if (oe_restart) begin
            oe_cnt <= OE_LOAD;
        end else if (oe_cnt != '0) begin
            oe_cnt <= oe_cnt - 1'b1;
        end
    end

    // Float window after the driving modes are left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt_cnt <= '0;
            drv_q   <= 1'b0;
        end else begin
            drv_q <= drive_mode;
            if (drive_mode) begin
                flt_cnt <= '0;
            end else if (drv_q) begin
                flt_cnt <= FLT_LOAD;
            end else if (flt_cnt != '0) begin
                flt_cnt <= flt_cnt - 1'b1;
            end
        end
    end

    assign dout_drive = drv_q || (flt_cnt != '0);
    assign dout_valid = drv_q && (acc_cnt == '0) && (oe_cnt == '0);
    assign dout       = dout_valid ? data_in : DATA_W'(GAP_BYTE);

endmodule

// File: rtl/byte_eprom_model.sv
// Top of the byte-wide EPROM model: samples the controls, finds strobe
// edges, routes writes into the array and feeds the output timer.
// Assumes: controls are synchronous to clk; one strobe edge per clock.
module byte_eprom_model
    import eprom_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         ACC_CYC  = 4,
    parameter int         OE_CYC   = 2,
    parameter int         FLT_CYC  = 2,
    parameter logic [7:0] MFR_ID   = 8'h8F,
    parameter logic [7:0] DEV_ID   = 8'h83,
    parameter logic [7:0] GAP_BYTE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              prog_n,
    input  logic              hv_supply,
    input  logic              vcc_boost,
    input  logic              id_hv,
    input  logic              erase_all,
    output logic [7:0]        rdata,
    output logic              rdata_drive,
    output logic              rdata_valid,
    output logic              access_err
);

    localparam int DATA_W = 8;

    eprom_mode_e       mode;
    logic              sel_q;
    logic              oen_q;
    logic              prog_q;
    logic              id_q;
    logic [ADDR_W-1:0] addr_q;
    logic              err_q;
    logic              prog_fall;
    logic              wr_now;
    logic              err_now;
    logic              acc_restart;
    logic              oe_restart;
    logic [DATA_W-1:0] cell_byte;
    logic [DATA_W-1:0] id_byte;
    logic [DATA_W-1:0] src_byte;

    eprom_mode_dec u_dec (
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .prog_n     (prog_n),
        .hv_supply  (hv_supply),
        .vcc_boost  (vcc_boost),
        .mode       (mode)
    );

    // Previous-edge copies of the controls used for edge and change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            oen_q  <= 1'b1;
            prog_q <= 1'b1;
            id_q   <= 1'b0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            sel_q  <= chip_sel_n;
            oen_q  <= out_en_n;
            prog_q <= prog_n;
            id_q   <= id_hv;
            addr_q <= addr;
            err_q  <= err_now;
        end
    end

    // Strobe edge qualification and delay restart causes.
    always_comb begin
        prog_fall   = prog_q && !prog_n;
        wr_now      = prog_fall && (mode == EM_PROGRAM);
        err_now     = prog_fall && !chip_sel_n && (mode != EM_PROGRAM);
        acc_restart = (addr != addr_q) || (id_hv != id_q) ||
                      (sel_q && !chip_sel_n) || wr_now || erase_all;
        oe_restart  = oen_q && !out_en_n;
    end

    eprom_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_all (erase_all),
        .wr_en     (wr_now),
        .wr_addr   (addr),
        .wr_data   (wdata),
        .rd_addr   (addr_q),
        .rd_data   (cell_byte)
    );

    // Identification byte picked by the lowest address bit.
    assign id_byte  = addr_q[0] ? DEV_ID : MFR_ID;
    assign src_byte = id_q ? id_byte : cell_byte;

    eprom_out_timer #(
        .DATA_W   (DATA_W),
        .ACC_CYC  (ACC_CYC),
        .OE_CYC   (OE_CYC),
        .FLT_CYC  (FLT_CYC),
        .GAP_BYTE (GAP_BYTE)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_restart (acc_restart),
        .oe_restart  (oe_restart),
        .drive_mode  (mode_drives(mode)),
        .data_in     (src_byte),
        .dout        (rdata),
        .dout_drive  (rdata_drive),
        .dout_valid  (rdata_valid)
    );

    assign access_err = err_q;

endmodule

// File: rtl/eprom_model_chk.sv
// Checker for the EPROM model: temporal rules on its ports.
// Assumes: all delay parameters of the model are at least 1.
module eprom_model_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              chip_sel_n,
    input logic              out_en_n,
    input logic              prog_n,
    input logic              hv_supply,
    input logic              vcc_boost,
    input logic              rdata_drive,
    input logic              rdata_valid,
    input logic              access_err
);

    assert_valid_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> rdata_drive);

    assert_valid_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (!$past(chip_sel_n) && !$past(out_en_n)));

    assert_addr_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> ($past(addr) == $past(addr, 2)));

    assert_float_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> rdata_drive);

    assert_no_vpp_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(prog_n) && !prog_n && !chip_sel_n && !hv_supply) |=> access_err);

    assert_inhibit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> !access_err);

    assert_fault_dark_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && hv_supply && !vcc_boost) |=> !rdata_valid);

endmodule

bind byte_eprom_model eprom_model_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .chip_sel_n  (chip_sel_n),
    .out_en_n    (out_en_n),
    .prog_n      (prog_n),
    .hv_supply   (hv_supply),
    .vcc_boost   (vcc_boost),
    .rdata_drive (rdata_drive),
    .rdata_valid (rdata_valid),
    .access_err  (access_err)
);

// File: tb/byte_eprom_model_tb.sv
`timescale 1ns/1ps
module byte_eprom_model_tb;

    localparam int         AW   = 8;
    localparam int         ACC  = 4;
    localparam int         OED  = 2;
    localparam int         FLT  = 2;
    localparam logic [7:0] GAP  = 8'hA5;
    localparam logic [7:0] MFR  = 8'h8F;
    localparam logic [7:0] DEV  = 8'h83;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic          chip_sel_n = 1'b1;
    logic          out_en_n = 1'b1;
    logic          prog_n = 1'b1;
    logic          hv_supply = 1'b0;
    logic          vcc_boost = 1'b0;
    logic          id_hv = 1'b0;
    logic          erase_all = 1'b0;
    logic [7:0]    rdata;
    logic          rdata_drive;
    logic          rdata_valid;
    logic          access_err;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    live    = 1'b0;
    bit    ended   = 1'b0;

    always #4 clk = ~clk;

    byte_eprom_model #(
        .ADDR_W(AW), .ACC_CYC(ACC), .OE_CYC(OED), .FLT_CYC(FLT),
        .MFR_ID(MFR), .DEV_ID(DEV), .GAP_BYTE(GAP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .prog_n(prog_n),
        .hv_supply(hv_supply), .vcc_boost(vcc_boost), .id_hv(id_hv),
        .erase_all(erase_all), .rdata(rdata), .rdata_drive(rdata_drive),
        .rdata_valid(rdata_valid), .access_err(access_err)
    );

    // Behavioural reference model, advanced on each rising edge.
    logic [7:0]    m_mem [256];
    int            m_acc, m_oe, m_flt;
    bit            m_en, m_err;
    bit            p_sel, p_oen, p_prog, p_id;
    logic [AW-1:0] p_addr;
    logic [7:0]    m_src;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_acc = 0; m_oe = 0; m_flt = 0; m_en = 0; m_err = 0;
            p_sel = 1; p_oen = 1; p_prog = 1; p_id = 0; p_addr = '0;
        end else begin
            bit en_now, prog_mode, fall, wr, trig;
            en_now    = !chip_sel_n && !out_en_n && (hv_supply ? (vcc_boost && prog_n) : 1'b1);
            prog_mode = !chip_sel_n && hv_supply && vcc_boost && out_en_n && !prog_n;
            fall      = p_prog && !prog_n;
            wr        = fall && prog_mode;
            m_err     = fall && !chip_sel_n && !prog_mode;
            if (erase_all) foreach (m_mem[i]) m_mem[i] = 8'hFF;
            else if (wr) m_mem[addr] = m_mem[addr] & wdata;
            trig  = (addr != p_addr) || (id_hv != p_id) || (p_sel && !chip_sel_n) || wr || erase_all;
            m_acc = trig ? ACC : (m_acc > 0 ? m_acc - 1 : 0);
            m_oe  = (p_oen && !out_en_n) ? OED : (m_oe > 0 ? m_oe - 1 : 0);
            if (en_now) m_flt = 0;
            else if (m_en) m_flt = FLT;
            else if (m_flt > 0) m_flt = m_flt - 1;
            m_en = en_now;
            p_sel = chip_sel_n; p_oen = out_en_n; p_prog = prog_n; p_id = id_hv; p_addr = addr;
        end
        m_src = p_id ? (p_addr[0] ? DEV : MFR) : m_mem[p_addr];
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (live && !ended) begin
            bit       e_drv, e_val;
            logic [7:0] e_dat;
            e_drv = m_en || (m_flt > 0);
            e_val = m_en && (m_acc == 0) && (m_oe == 0);
            e_dat = e_val ? m_src : GAP;
            n_tests++;
            if (rdata_drive !== e_drv || rdata_valid !== e_val ||
                rdata !== e_dat || access_err !== m_err) begin
                n_fail++;
                $display("FAIL %s cycle model: drv=%0b val=%0b data=%02h err=%0b expected drv=%0b val=%0b data=%02h err=%0b",
                         phase, rdata_drive, rdata_valid, rdata, access_err, e_drv, e_val, e_dat, m_err);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp_v);
        end
    endtask

    task automatic chk_read(input string req, input logic [7:0] exp_v);
        chk(req, {7'd0, rdata_valid}, 8'd1);
        chk(req, rdata, exp_v);
    endtask

    task automatic pulse_prog;
        prog_n = 1'b0; step(1);
        prog_n = 1'b1; step(1);
    endtask

    task automatic wrap_up;
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        wrap_up();
    end

    initial begin
        step(4);
        live = 1'b1;
        phase = "R1";
        chk("R1 drive", {7'd0, rdata_drive}, 8'd0);
        chk("R1 valid", {7'd0, rdata_valid}, 8'd0);
        chk("R1 data", rdata, GAP);
        rst_n = 1'b1;
        step(1);
        chk("R1 err", {7'd0, access_err}, 8'd0);
        chk("R1 gap", rdata, GAP);

        // R2 / R4: read a blank byte after select falls.
        phase = "R4";
        addr = 8'd5; chip_sel_n = 1'b0; out_en_n = 1'b0;
        step(ACC);
        chk("R4 driven early", {7'd0, rdata_drive}, 8'd1);
        chk("R4 gap early", rdata, GAP);
        phase = "R2";
        step(1);
        chk_read("R2 blank", 8'hFF);
        phase = "R4";
        addr = 8'd9;
        step(1);
        chk("R4 addr restart", {7'd0, rdata_valid}, 8'd0);
        step(ACC);
        chk_read("R4 new addr", 8'hFF);

        // R6: float after output enable rises.
        phase = "R6";
        out_en_n = 1'b1;
        step(1);
        chk("R6 still driven", {7'd0, rdata_drive}, 8'd1);
        chk("R6 not valid", {7'd0, rdata_valid}, 8'd0);
        step(FLT);
        chk("R6 released", {7'd0, rdata_drive}, 8'd0);

        // R5: short delay from output enable.
        phase = "R5";
        out_en_n = 1'b0;
        step(OED);
        chk("R5 early", {7'd0, rdata_valid}, 8'd0);
        step(1);
        chk_read("R5 oe read", 8'hFF);

        // R3: standby regardless of enable and strobe.
        phase = "R3";
        chip_sel_n = 1'b1; prog_n = 1'b0;
        step(FLT + 1);
        chk("R3 standby", {7'd0, rdata_drive}, 8'd0);
        step(3);
        chk("R3 standby hold", {7'd0, rdata_drive}, 8'd0);
        prog_n = 1'b1;
        step(1);

        // R7: two writes with overlapping patterns, then verify.
        phase = "R7";
        hv_supply = 1'b1; vcc_boost = 1'b1; chip_sel_n = 1'b0; out_en_n = 1'b1;
        addr = 8'd5; wdata = 8'hA7;
        step(2);
        pulse_prog();
        wdata = 8'h5F;
        pulse_prog();
        chk("R7 no err", {7'd0, access_err}, 8'd0);
        out_en_n = 1'b0;
        step(ACC + 1);
        chk_read("R7 and", 8'h07);

        // R8: strobe held low writes once.
        phase = "R8";
        out_en_n = 1'b1; addr = 8'd6; wdata = 8'hFE;
        step(1);
        prog_n = 1'b0; step(1);
        wdata = 8'h00; step(5);
        prog_n = 1'b1; step(1);
        out_en_n = 1'b0;
        step(ACC + 1);
        chk_read("R8 held low", 8'hFE);

        // R9: inhibit ignores the strobe.
        phase = "R9";
        out_en_n = 1'b1; chip_sel_n = 1'b1; addr = 8'd7; wdata = 8'h00;
        step(1);
        prog_n = 1'b0; step(1);
        chk("R9 no err", {7'd0, access_err}, 8'd0);
        prog_n = 1'b1; step(1);
        chip_sel_n = 1'b0; out_en_n = 1'b0;
        step(ACC + 1);
        chk_read("R9 unchanged", 8'hFF);

        // R10: strobe without programming voltage.
        phase = "R10";
        hv_supply = 1'b0; vcc_boost = 1'b0; out_en_n = 1'b1; addr = 8'd8;
        step(1);
        prog_n = 1'b0; step(1);
        chk("R10 err pulse", {7'd0, access_err}, 8'd1);
        step(1);
        chk("R10 err ends", {7'd0, access_err}, 8'd0);
        prog_n = 1'b1; out_en_n = 1'b0;
        step(ACC + 1);
        chk_read("R10 unchanged", 8'hFF);

        // R11: supply fault and enable/strobe clash.
        phase = "R11";
        hv_supply = 1'b1; vcc_boost = 1'b0;
        step(FLT + 2);
        chk("R11 dark", {7'd0, rdata_drive}, 8'd0);
        out_en_n = 1'b1; step(1);
        prog_n = 1'b0; step(1);
        chk("R11 fault err", {7'd0, access_err}, 8'd1);
        prog_n = 1'b1; vcc_boost = 1'b1; out_en_n = 1'b0;
        step(ACC + 1);
        chk_read("R11 unchanged", 8'hFF);
        prog_n = 1'b0; step(1);
        chk("R11 clash err", {7'd0, access_err}, 8'd1);
        chk("R11 clash invalid", {7'd0, rdata_valid}, 8'd0);
        prog_n = 1'b1;

        // R12: identification bytes.
        phase = "R12";
        hv_supply = 1'b0; vcc_boost = 1'b0; id_hv = 1'b1; addr = 8'd0;
        step(ACC + 1);
        chk_read("R12 maker", MFR);
        addr = 8'd1;
        step(ACC + 1);
        chk_read("R12 device", DEV);
        id_hv = 1'b0;
        step(1);
        chk("R12 id restart", {7'd0, rdata_valid}, 8'd0);
        step(ACC);
        chk_read("R12 back to array", 8'hFF);

        // R13: erase.
        phase = "R13";
        addr = 8'd5;
        step(ACC + 1);
        chk_read("R13 before", 8'h07);
        erase_all = 1'b1; step(1);
        erase_all = 1'b0;
        chk("R13 restart", {7'd0, rdata_valid}, 8'd0);
        step(ACC);
        chk_read("R13 blank 5", 8'hFF);
        addr = 8'd6;
        step(ACC + 1);
        chk_read("R13 blank 6", 8'hFF);

        step(2);
        wrap_up();
    end

endmodule